// File: doc/BRIEF.md
# Cascadable Reload Timer Pair

This block holds two 8-bit down-counters, each with its own reload value, mode register and underflow interrupt flags, all reached over a small register bus. A counter steps once per selected clock source. The source is either a prescaled tick supplied from outside or the underflow event of the lower timer. When a counter sits at zero and the next step arrives, it reloads and emits an underflow pulse. That pulse also sets the timer's interrupt request.

When the upper timer is switched to count on the lower timer's underflow, the pair behaves as one 16-bit down-counter. The lower reload register holds the low byte and the upper one holds the high byte. The combined period is the 16-bit value plus one tick: low 0x5F with high 0xEA gives 60000 ticks. While the chain is active, the lower counter wraps to 0xFF instead of reloading, as long as the upper counter is not yet zero.

Each counter is controlled by a two-state machine. ST_COUNT means the count is non-zero, and a step decrements it. ST_ZERO means the count is zero, and a step reloads it and raises the underflow. The transitions are:
- ST_COUNT to ST_ZERO when the next count is zero.
- ST_ZERO to ST_COUNT when the reloaded or wrapped value is non-zero.
- ST_ZERO to ST_ZERO when the reload value is zero.
- Either state to the state that matches the base value when the load bit is written.

Top module: `reload_timer_pair`

## Requirements
- R1: After reset, every register reads 0, both counters are 0, and `uflow_o` and `irq_o` are 0.
- R2: Register map: timer t uses addresses {t,00} base, {t,01} mode, {t,10} interrupt control, {t,11} counter (read-only). Writing the mode register with bit 6 set copies the base value into the counter at that edge. Bit 6 always reads 0.
- R3: The mode register holds enable in bit 7 and the source select in bits 1:0. Select 00 means the external tick, 01 means the lower timer's underflow (timer 0 never steps on 01), and 10 or 11 means no source. A counter changes only on a step, which needs enable = 1 and an active selected source, or on a load.
- R4: A base value N gives one underflow every N+1 steps. The counter reloads N on the step taken at zero. The `uflow_o` bit is high for exactly the one cycle after that step edge, so base 0 underflows on every step.
- R5: With timer 1 enabled on select 01, timer 1 steps on the same edge as timer 0 underflows. Timer 0 then wraps to 0xFF while timer 1 is non-zero, and reloads when timer 1 is zero. The period is (high*256+low)+1 ticks, and timer 1 underflows once per period.
- R6: A write to the mode register changes the select bits only if enable was 0 before that write. Enable itself is always written.
- R7: Interrupt control bit 1 is the request. It is set by an underflow and cleared by a write with bit 1 = 0. Writing 1 does not set it, and an underflow in the same cycle as a clear wins.
- R8: Interrupt control bits 7:5 are a stored priority level and bit 4 is the enable. `irq_o[t]` equals request AND enable, and bit 0 reads back that value (detect).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_in | input | 1 | Prescaled base tick, one cycle per count |
| bus_addr | input | 3 | Register address: bit 2 selects the timer, bits 1:0 the register |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| uflow_o | output | 2 | Per-timer one-cycle underflow pulse |
| irq_o | output | 2 | Per-timer interrupt request (request AND enable) |

## Verification
A write takes effect at the edge that samples it, and reads are combinational, so a read-back is sampled in the low phase of the following cycle. A counter enabled at edge E with count c underflows at edge E+c+1. Its `uflow_o` pulse and request flag are sampled at the falling edge after that edge, and `irq_o` follows in the same half cycle. The driver pushes the cycle number of every expected underflow into a per-timer queue before the stimulus starts. The monitor pops an entry at each falling edge where a pulse appears, so a pulse that comes early, comes late, is missing or is extra is reported against R4 or R5.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    localparam int TMR_W  = 8;
    localparam int TMR_N  = 2;
    localparam int ADDR_W = 3;

    typedef enum logic [1:0] {
        SRC_TICK = 2'b00,
        SRC_CASC = 2'b01,
        SRC_NONE = 2'b10,
        SRC_RSVD = 2'b11
    } src_e;

    typedef enum logic {
        ST_COUNT = 1'b0,
        ST_ZERO  = 1'b1
    } tstate_e;

    localparam logic [1:0] OFS_BASE = 2'd0;
    localparam logic [1:0] OFS_MODE = 2'd1;
    localparam logic [1:0] OFS_ICTL = 2'd2;
    localparam logic [1:0] OFS_CNT  = 2'd3;
endpackage

// File: rtl/tmr_core.sv
module tmr_core #(
    parameter int W = tmr_pkg::TMR_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  tmr_pkg::src_e sel,
    input  logic          tick_in,
    input  logic          casc_in,
    input  logic          ld,
    input  logic          wrap_full,
    input  logic [W-1:0]  base,
    output logic [W-1:0]  cnt_o,
    output logic          uf_evt,
    output logic          uflow_o
);
    import tmr_pkg::*;

    localparam logic [W-1:0] ONE = W'(1);

    tstate_e      state_q, state_d;
    logic [W-1:0] cnt_q, cnt_d;
    logic         step;

    // source selection
    always_comb begin
        unique case (sel)
            SRC_TICK: step = en & tick_in;
            SRC_CASC: step = en & casc_in;
            SRC_NONE: step = 1'b0;
            SRC_RSVD: step = 1'b0;
        endcase
    end

    // next count, next state and underflow event
    always_comb begin
        cnt_d  = cnt_q;
        uf_evt = 1'b0;
        if (ld) begin
            cnt_d = base;
        end else if (step) begin
            unique case (state_q)
                ST_ZERO: begin
                    uf_evt = 1'b1;
                    cnt_d  = wrap_full ? '1 : base;
                end
                ST_COUNT: cnt_d = cnt_q - ONE;
            endcase
        end
        state_d = (cnt_d == '0) ? ST_ZERO : ST_COUNT;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_ZERO;
        else        state_q <= state_d;
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            uflow_o <= 1'b0;
        end else begin
            cnt_q   <= cnt_d;
            uflow_o <= uf_evt;
        end
    end

    assign cnt_o = cnt_q;
endmodule

// File: rtl/tmr_irq.sv
module tmr_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic uf_evt,
    input  logic clr_req,
    input  logic ie,
    output logic req_o,
    output logic irq_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       req_o <= 1'b0;
        else if (uf_evt)  req_o <= 1'b1;
        else if (clr_req) req_o <= 1'b0;
    end

    assign irq_o = req_o & ie;
endmodule

// File: rtl/tmr_regs.sv
module tmr_regs #(
    parameter int W  = tmr_pkg::TMR_W,
    parameter int NT = tmr_pkg::TMR_N
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [2:0]             bus_addr,
    input  logic [W-1:0]           bus_wdata,
    input  logic                   bus_we,
    output logic [W-1:0]           bus_rdata,
    input  logic [NT-1:0][W-1:0]   cnt_i,
    input  logic [NT-1:0]          req_i,
    input  logic [NT-1:0]          irq_i,
    output logic [NT-1:0]          en_o,
    output logic [NT-1:0][1:0]     sel_o,
    output logic [NT-1:0]          ld_o,
    output logic [NT-1:0][W-1:0]   base_o,
    output logic [NT-1:0]          ie_o,
    output logic [NT-1:0]          clr_o
);
    import tmr_pkg::*;

    localparam int EN_B  = W - 1;
    localparam int LD_B  = W - 2;
    localparam int IE_B  = W - 4;
    localparam int REQ_B = 1;

    logic [1:0]            ofs;
    logic                  tsel;
    logic [NT-1:0][2:0]    lvl_q;

    assign ofs  = bus_addr[1:0];
    assign tsel = bus_addr[2];

    for (genvar t = 0; t < NT; t++) begin : g_reg
        logic hit;
        assign hit = bus_we && (tsel == 1'(t));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                base_o[t] <= '0;
                en_o[t]   <= 1'b0;
                sel_o[t]  <= 2'b00;
                lvl_q[t]  <= 3'd0;
                ie_o[t]   <= 1'b0;
            end else if (hit) begin
                case (ofs)
                    OFS_BASE: base_o[t] <= bus_wdata;
                    OFS_MODE: begin
                        en_o[t] <= bus_wdata[EN_B];
                        if (!en_o[t]) sel_o[t] <= bus_wdata[1:0];
                    end
                    OFS_ICTL: begin
                        lvl_q[t] <= bus_wdata[W-1 -: 3];
                        ie_o[t]  <= bus_wdata[IE_B];
                    end
                    default: ;
                endcase
            end
        end

        assign ld_o[t]  = hit && (ofs == OFS_MODE) && bus_wdata[LD_B];
        assign clr_o[t] = hit && (ofs == OFS_ICTL) && !bus_wdata[REQ_B];
    end

    always_comb begin
        case (ofs)
            OFS_BASE: bus_rdata = base_o[tsel];
            OFS_MODE: bus_rdata = {en_o[tsel], {(W-3){1'b0}}, sel_o[tsel]};
            OFS_ICTL: bus_rdata = {lvl_q[tsel], ie_o[tsel], {(W-6){1'b0}},
                                   req_i[tsel], irq_i[tsel]};
            default:  bus_rdata = cnt_i[tsel];
        endcase
    end
endmodule

// File: rtl/reload_timer_pair.sv
module reload_timer_pair #(
    parameter int W = tmr_pkg::TMR_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick_in,
    input  logic [2:0]   bus_addr,
    input  logic [W-1:0] bus_wdata,
    input  logic         bus_we,
    output logic [W-1:0] bus_rdata,
    output logic [1:0]   uflow_o,
    output logic [1:0]   irq_o
);
    import tmr_pkg::*;

    localparam int NT = TMR_N;

    logic [NT-1:0]          en_v, ld_v, ie_v, clr_v, uf_v, req_v, casc_v, wrap_v;
    logic [NT-1:0][1:0]     sel_v;
    logic [NT-1:0][W-1:0]   base_v, cnt_v;
    logic                   chain_on;

    tmr_regs #(.W(W), .NT(NT)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_we    (bus_we),
        .bus_rdata (bus_rdata),
        .cnt_i     (cnt_v),
        .req_i     (req_v),
        .irq_i     (irq_o),
        .en_o      (en_v),
        .sel_o     (sel_v),
        .ld_o      (ld_v),
        .base_o    (base_v),
        .ie_o      (ie_v),
        .clr_o     (clr_v)
    );

    // upper timer chained onto the lower one
    assign chain_on  = en_v[1] && (sel_v[1] == SRC_CASC);
    assign casc_v[0] = 1'b0;
    assign casc_v[1] = uf_v[0];
    assign wrap_v[0] = chain_on && (cnt_v[1] != '0);
    assign wrap_v[1] = 1'b0;

    for (genvar t = 0; t < NT; t++) begin : g_tmr
        tmr_core #(.W(W)) u_core (
            .clk       (clk),
            .rst_n     (rst_n),
            .en        (en_v[t]),
            .sel       (src_e'(sel_v[t])),
            .tick_in   (tick_in),
            .casc_in   (casc_v[t]),
            .ld        (ld_v[t]),
            .wrap_full (wrap_v[t]),
            .base      (base_v[t]),
            .cnt_o     (cnt_v[t]),
            .uf_evt    (uf_v[t]),
            .uflow_o   (uflow_o[t])
        );

        tmr_irq u_irq (
            .clk     (clk),
            .rst_n   (rst_n),
            .uf_evt  (uf_v[t]),
            .clr_req (clr_v[t]),
            .ie      (ie_v[t]),
            .req_o   (req_v[t]),
            .irq_o   (irq_o[t])
        );
    end
endmodule

// File: rtl/tmr_pair_chk.sv
module tmr_pair_chk #(
    parameter int W = tmr_pkg::TMR_W
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [1:0]            en_v,
    input logic [1:0][1:0]       sel_v,
    input logic [1:0]            ld_v,
    input logic [1:0][W-1:0]     base_v,
    input logic [1:0][W-1:0]     cnt_v,
    input logic [1:0]            req_v,
    input logic [1:0]            ie_v,
    input logic [1:0]            uflow_o,
    input logic [1:0]            irq_o
);
    for (genvar t = 0; t < 2; t++) begin : g_chk
        // R8
        irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
            irq_o[t] |-> (ie_v[t] && req_v[t]));

        // R7
        uf_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
            uflow_o[t] |-> req_v[t]);

        // R6
        sel_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $past(en_v[t]) |-> $stable(sel_v[t]));

        // R2
        load_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $past(ld_v[t]) |-> (cnt_v[t] == $past(base_v[t])));

        // R3
        hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!$past(en_v[t]) && !$past(ld_v[t])) |-> $stable(cnt_v[t]));
    end
endmodule

bind reload_timer_pair tmr_pair_chk #(.W(W)) u_tmr_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .en_v    (en_v),
    .sel_v   (sel_v),
    .ld_v    (ld_v),
    .base_v  (base_v),
    .cnt_v   (cnt_v),
    .req_v   (req_v),
    .ie_v    (ie_v),
    .uflow_o (uflow_o),
    .irq_o   (irq_o)
);

// File: tb/reload_timer_pair_bench.sv
module reload_timer_pair_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       we = 1'b0;
    logic [2:0] addr = 3'd0;
    logic [7:0] wdata = 8'd0;
    logic [7:0] rdata;
    logic [1:0] uflow, irq;

    int cyc = 0;
    int n_chk = 0;
    int n_err = 0;
    int q0[$];
    int q1[$];
    int e_cyc;

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    reload_timer_pair u_reload_timer_pair (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_in   (tick),
        .bus_addr  (addr),
        .bus_wdata (wdata),
        .bus_we    (we),
        .bus_rdata (rdata),
        .uflow_o   (uflow),
        .irq_o     (irq)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; we = 1'b1;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, input int exp, input string tag);
        @(negedge clk);
        addr = a;
        #1;
        check(tag, int'(rdata), exp);
    endtask

    task automatic expect_uf(input int t, input int c);
        if (t == 0) q0.push_back(c);
        else        q1.push_back(c);
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n) begin
            if (uflow[0]) begin
                if (q0.size() == 0) check("R4 timer0 unexpected underflow cycle", cyc, -1);
                else                check("R4 timer0 underflow cycle", cyc, q0.pop_front());
            end
            if (uflow[1]) begin
                if (q1.size() == 0) check("R5 timer1 unexpected underflow cycle", cyc, -1);
                else                check("R5 timer1 underflow cycle", cyc, q1.pop_front());
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        for (int a = 0; a < 8; a++) rd(3'(a), 0, "R1 register after reset");
        check("R1 uflow after reset", int'(uflow), 0);
        check("R1 irq after reset", int'(irq), 0);

        // R2 load copies base
        wr(3'd0, 8'd3);
        wr(3'd1, 8'h40);
        rd(3'd3, 3, "R2 counter after load");
        rd(3'd1, 0, "R2 load bit reads 0");

        // R4 free-running period of base+1 ticks
        tick = 1'b1;
        wr(3'd1, 8'h80);
        e_cyc = cyc;
        expect_uf(0, e_cyc + 4);
        expect_uf(0, e_cyc + 8);
        expect_uf(0, e_cyc + 12);
        while (cyc < e_cyc + 12) @(negedge clk);
        wr(3'd1, 8'h00);
        repeat (4) @(negedge clk);
        rd(3'd3, 1, "R3 counter holds once disabled");
        tick = 1'b0;

        // R3 no step without tick
        wr(3'd0, 8'd5);
        wr(3'd1, 8'h40);
        wr(3'd1, 8'h80);
        repeat (5) @(negedge clk);
        rd(3'd3, 5, "R3 counter holds without tick");
        @(negedge clk); tick = 1'b1;
        @(negedge clk);
        @(negedge clk); tick = 1'b0;
        rd(3'd3, 3, "R3 two ticks step twice");

        // R6 select locked while enabled
        wr(3'd1, 8'h82);
        rd(3'd1, 8'h80, "R6 select ignored while enabled");
        wr(3'd1, 8'h00);
        wr(3'd1, 8'h02);
        rd(3'd1, 8'h02, "R6 select written while disabled");
        wr(3'd1, 8'h82);
        rd(3'd1, 8'h82, "R6 enable with held select");
        tick = 1'b1;
        repeat (5) @(negedge clk);
        tick = 1'b0;
        rd(3'd3, 3, "R3 select 10 gives no step");
        wr(3'd1, 8'h00);
        wr(3'd1, 8'h00);

        // R7 R8 interrupt flags
        wr(3'd2, 8'hB0);
        rd(3'd2, 8'hB0, "R8 level and enable readback");
        wr(3'd0, 8'd1);
        wr(3'd1, 8'h40);
        wr(3'd1, 8'h80);
        e_cyc = cyc;
        expect_uf(0, e_cyc + 2);
        tick = 1'b1;
        @(negedge clk);
        @(negedge clk);
        tick = 1'b0;
        #1;
        check("R8 irq after underflow", int'(irq[0]), 1);
        rd(3'd2, 8'hB3, "R7 request and detect set");
        wr(3'd2, 8'hB0);
        #1;
        check("R7 irq after clear", int'(irq[0]), 0);
        rd(3'd2, 8'hB0, "R7 request cleared by 0");
        wr(3'd2, 8'hA0);
        e_cyc = cyc;
        expect_uf(0, e_cyc + 2);
        tick = 1'b1;
        @(negedge clk);
        @(negedge clk);
        tick = 1'b0;
        #1;
        check("R8 irq masked by enable", int'(irq[0]), 0);
        rd(3'd2, 8'hA2, "R8 request without detect");
        wr(3'd2, 8'hA2);
        rd(3'd2, 8'hA2, "R7 writing 1 keeps request");
        wr(3'd2, 8'hA0);
        rd(3'd2, 8'hA0, "R7 cleared again");

        // R4 base zero underflows on every tick
        wr(3'd1, 8'h00);
        wr(3'd0, 8'd0);
        wr(3'd1, 8'h40);
        wr(3'd1, 8'h80);
        e_cyc = cyc;
        expect_uf(0, e_cyc + 1);
        expect_uf(0, e_cyc + 2);
        expect_uf(0, e_cyc + 3);
        tick = 1'b1;
        repeat (3) @(negedge clk);
        tick = 1'b0;
        wr(3'd1, 8'h00);
        wr(3'd2, 8'h00);

        // R5 16-bit cascade, 0xEA5F + 1 = 60000 ticks
        wr(3'd4, 8'hEA);
        wr(3'd0, 8'h5F);
        wr(3'd5, 8'h41);
        wr(3'd1, 8'h40);
        wr(3'd5, 8'h81);
        rd(3'd5, 8'h81, "R5 upper timer in chain mode");
        tick = 1'b1;
        wr(3'd1, 8'h80);
        e_cyc = cyc;
        for (int k = 0; k < 235; k++) expect_uf(0, e_cyc + 96 + 256 * k);
        expect_uf(1, e_cyc + 60000);
        while (cyc < e_cyc + 60000) @(negedge clk);
        tick = 1'b0;
        rd(3'd3, 8'h5F, "R5 lower reloaded after full period");
        rd(3'd7, 8'hEA, "R5 upper reloaded after full period");
        rd(3'd6, 8'h02, "R7 upper request set by underflow");

        check("R4 timer0 pending underflows", q0.size(), 0);
        check("R5 timer1 pending underflows", q1.size(), 0);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule